// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the sequence of column addresses that a synchronous DRAM burst walks through. A start strobe captures a 9-bit start column, a burst length code and an ordering bit. From the following clock on, the block presents one column per cycle with a beat-valid flag. It raises a last-beat flag on the final beat of a fixed-length burst.

Two beat orderings are supported. In sequential order the low bits count up and wrap inside the aligned block, while the upper bits stay fixed. In interleaved order the low bits of the start column are XORed with the beat index. A full-page length walks the entire 512-column row modulo 512 and never ends by itself. A stop input ends any burst early, and a fresh start takes over from a running burst in the next cycle. The surrounding controller uses the outputs to drive the column address pins and to pace its data path.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, valid_o and last_o are 0.
- R2: When start_i is high at a rising edge, valid_o is 1 in the following cycle and col_o equals the captured start column. Each further beat follows one cycle after the previous one.
- R3: Length codes are decoded as follows: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats and 7 gives a full page. Codes 4, 5 and 6 behave as 1 beat. A fixed-length burst shows exactly that many valid beats, with last_o high on the final one only, and valid_o low in the cycle after it.
- R4: With interleave_i = 0 and length L, beat k keeps the start column's bits above log2(L). Its low log2(L) bits are (start low bits + k) mod L.
- R5: With interleave_i = 1 and length L, beat k keeps the upper bits. Its low log2(L) bits are start low bits XOR k.
- R6: In full-page mode beat k is (start + k) mod 512 whatever interleave_i is. last_o is never raised, and beats continue until a stop or a new start.
- R7: stop_i high at an edge without start_i ends the burst: valid_o and last_o are 0 from the next cycle. A stop while idle has no effect.
- R8: A start during a running burst abandons it, and the new burst's first beat appears in the next cycle. Start takes priority over stop in the same cycle.
- R9: start_col_i, bl_code_i and interleave_i are used only in the cycle of a start. Changing them during a burst leaves the running beats unchanged.
- R10: Starts on consecutive clocks each produce their own first beat, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture a new burst this cycle |
| start_col_i | input | 9 | Start column of the burst |
| bl_code_i | input | 3 | Burst length code (see R3) |
| interleave_i | input | 1 | 0 = sequential order, 1 = interleaved order |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench builds the block with its defaults: a 9-bit column and a 3-bit length code. This keeps the 512-column full-page wrap and every length code, including the reserved ones, within reach of short directed runs. Start columns near the top of the row push full-page bursts across the 511-to-0 boundary. They also place fixed-length bursts at misaligned offsets, where the difference between sequential wrap and interleaved XOR is visible.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int unsigned CODE_W = 3;

  localparam logic [CODE_W-1:0] LEN_1    = 3'd0;
  localparam logic [CODE_W-1:0] LEN_2    = 3'd1;
  localparam logic [CODE_W-1:0] LEN_4    = 3'd2;
  localparam logic [CODE_W-1:0] LEN_8    = 3'd3;
  localparam logic [CODE_W-1:0] LEN_PAGE = 3'd7;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_XOR = 1'b1
  } beat_order_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o
);
  localparam int unsigned MAX_LOG2 = 3;

  logic [MAX_LOG2:0] log2_len;

  always_comb begin
    full_o = 1'b0;
    unique case (code_i)
      LEN_2:    log2_len = 1;
      LEN_4:    log2_len = 2;
      LEN_8:    log2_len = 3;
      LEN_PAGE: begin
        log2_len = 0;
        full_o   = 1'b1;
      end
      default:  log2_len = 0;  // length 1, reserved codes included
    endcase
  end

  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask_o[b] = full_o || (b < int'(log2_len));
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  beat_order_e      order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] xor_col;

  assign sum     = base_i + idx_i;
  assign seq_col = (base_i & ~mask_i) | (sum & mask_i);
  assign xor_col = base_i ^ (idx_i & mask_i);

  always_comb begin
    if (full_i)                  col_o = sum;  // whole row, modulo 2^COL_W
    else if (order_i == ORDER_XOR) col_o = xor_col;
    else                         col_o = seq_col;
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  beat_order_e      order_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output beat_order_e      order_o,
  output logic             last_o
);
  logic at_end;

  assign at_end = !full_o && (idx_o == mask_o);
  assign last_o = active_o && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      base_o   <= '0;
      idx_o    <= '0;
      mask_o   <= '0;
      full_o   <= 1'b0;
      order_o  <= ORDER_SEQ;
    end else if (start_i) begin
      // a new start overrides both stop and a running burst
      active_o <= 1'b1;
      base_o   <= start_col_i;
      idx_o    <= '0;
      mask_o   <= mask_i;
      full_o   <= full_i;
      order_o  <= order_i;
    end else if (stop_i) begin
      active_o <= 1'b0;
    end else if (active_o) begin
      if (at_end) active_o <= 1'b0;
      else        idx_o    <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] bl_code_i,
  input  logic              interleave_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             act;
  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic             full_q;
  beat_order_e      order_q;
  beat_order_e      order_in;

  assign order_in = interleave_i ? ORDER_XOR : ORDER_SEQ;

  burst_len_decode #(.COL_W(COL_W)) i_decode (
    .code_i (bl_code_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .full_i      (dec_full),
    .order_i     (order_in),
    .active_o    (act),
    .base_o      (base_q),
    .idx_o       (idx_q),
    .mask_o      (mask_q),
    .full_o      (full_q),
    .order_o     (order_q),
    .last_o      (last_o)
  );

  burst_col_map #(.COL_W(COL_W)) i_map (
    .base_i  (base_q),
    .idx_i   (idx_q),
    .mask_i  (mask_q),
    .full_i  (full_q),
    .order_i (order_q),
    .col_o   (col_o)
  );

  assign valid_o = act;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  p_first_beat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && (col_o == $past(start_col_i)));

  p_last_is_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  p_end_after_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o);

  p_run_continues_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !start_i && !stop_i |=> valid_o);

  p_stop_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !valid_o && !last_o);

  p_idle_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !start_i |=> !valid_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       interleave_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit m_act = 0;
  int m_k = 0;
  int m_base = 0;
  int m_len = 1;   // 0 means full page
  bit m_il = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_col_gen i_burst_col_gen (
    .clk_i, .rst_ni, .start_i, .start_col_i, .bl_code_i,
    .interleave_i, .stop_i, .col_o, .valid_o, .last_o
  );

  function automatic int len_of(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int lo;
    if (m_len == 0) return (m_base + m_k) % 512;
    lo = m_base % m_len;
    if (m_il) return m_base - lo + (lo ^ m_k);
    return m_base - lo + ((lo + m_k) % m_len);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compare at negedge, drive inputs, advance model, wait for the edge
  task automatic step(bit s, int c, int code, bit il, bit p);
    bit e_last;
    @(negedge clk_i);
    e_last = m_act && (m_len != 0) && (m_k == m_len - 1);
    check(cur_req, "valid_o", int'(valid_o), int'(m_act));
    check(cur_req, "last_o", int'(last_o), int'(e_last));
    if (m_act) check(cur_req, "col_o", int'(col_o), exp_col());
    start_i = s; start_col_i = 9'(c); bl_code_i = 3'(code);
    interleave_i = il; stop_i = p;
    if (s) begin
      m_act = 1; m_k = 0; m_base = c; m_len = len_of(code); m_il = il;
    end else if (p) begin
      m_act = 0;
    end else if (m_act) begin
      if (e_last) m_act = 0;
      else m_k = (m_k + 1) % 512;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD * 3);
    check("R1", "valid_o in reset", int'(valid_o), 0);
    check("R1", "last_o in reset", int'(last_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(3);

    // R2, R3, R4: every length, sequential, misaligned start
    cur_req = "R4";
    for (int code = 0; code < 4; code++) begin
      step(1, 9'h1F6, code, 0, 0);
      idle(9);
    end
    cur_req = "R3";
    for (int code = 4; code < 7; code++) begin
      step(1, 9'h0A3, code, 0, 0);
      idle(3);
    end

    // R5: interleaved order
    cur_req = "R5";
    for (int code = 1; code < 4; code++) begin
      step(1, 9'h15D, code, 1, 0);
      idle(9);
    end

    // R6: full page across the 511 -> 0 boundary, then stop (R7)
    cur_req = "R6";
    step(1, 9'h1FC, 7, 1, 0);
    idle(12);
    cur_req = "R7";
    step(0, 0, 0, 0, 1);
    idle(3);
    step(0, 0, 0, 0, 1);  // stop while idle
    idle(2);

    // R7: stop mid burst of 8
    step(1, 9'h043, 3, 0, 0);
    idle(3);
    step(0, 0, 0, 0, 1);
    idle(3);

    // R8: start interrupts, and wins over a simultaneous stop
    cur_req = "R8";
    step(1, 9'h100, 3, 0, 0);
    idle(2);
    step(1, 9'h07E, 2, 1, 0);
    idle(1);
    step(1, 9'h1FF, 1, 0, 1);
    idle(4);

    // R9: capture-only inputs changed during a burst
    cur_req = "R9";
    step(1, 9'h0C5, 3, 0, 0);
    step(0, 9'h1AA, 7, 1, 0);
    step(0, 9'h033, 0, 1, 0);
    step(0, 9'h0FF, 2, 0, 0);
    idle(7);

    // R10: back-to-back starts
    cur_req = "R10";
    for (int i = 0; i < 6; i++) step(1, 9'h1F0 + i * 3, i % 4, i[0], 0);
    idle(9);

    finish_run();
  end
endmodule